// File: doc/BRIEF.md
# Mode-Configurable Serial Data FIFO

This block holds the byte queues between a serial channel's shift registers and its memory-side buffer logic. On the receive side, bytes from a deserializer are either packed four at a time into 32-bit words or released one character at a time. Each stored entry is offered to the buffer side through a valid/ready pair. On the transmit side, bytes from the buffer side go into a queue that the serializer drains on request. That queue is either deep or a single holding byte.

Two static mode inputs select the geometry. A word-oriented receive mode and a deep transmit queue suit frame-based traffic. The character receive mode and the one-byte transmit queue keep latency to a minimum for character-oriented traffic. Changing either mode input empties the queue it controls. Overrun and underrun flags record lost or missing bytes. Both flags stay set until reset or until the mode of their side changes.

Top module: `sdf_top`

## Requirements
- R1: After reset, rx_empty and tx_empty are 1, and rx_full, tx_full, rx_out_valid, rx_overrun and tx_underrun are 0.
- R2: With rx_narrow=0, the first three bytes of a group do not make rx_empty drop. On the fourth byte, one 32-bit entry is stored, with the first byte of the group in bits [7:0] and the fourth in bits [31:24].
- R3: With rx_narrow=1, every accepted byte is stored as its own entry in the cycle after it arrives. The byte sits in bits [7:0] and bits [31:8] are zero.
- R4: The receive queue holds 8 entries in either mode: 8 words (32 bytes) or 8 characters. rx_full is 1 when it holds 8. A byte that arrives while rx_full is 1 is dropped and sets rx_overrun, which stays 1.
- R5: With tx_single=0, the transmit queue holds 32 bytes and raises tx_full at 32. Writes while tx_full is 1 are ignored. Bytes leave in the order they were written.
- R6: With tx_single=1, the transmit queue holds one byte. tx_full is 1 as soon as it holds that byte, and a second write is ignored.
- R7: tx_req while tx_empty is 1 sets tx_underrun, which stays 1.
- R8: A change of rx_narrow empties the receive queue, discards any partly packed word and clears rx_overrun. After that edge, rx_empty is 1.
- R9: A change of tx_single empties the transmit queue and clears tx_underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_narrow | input | 1 | 1: character receive mode; 0: 32-bit word mode |
| tx_single | input | 1 | 1: one-byte transmit queue; 0: 32-byte queue |
| rx_byte_valid | input | 1 | Byte from deserializer present |
| rx_byte | input | 8 | Received byte |
| rx_out_valid | output | 1 | Receive entry available to the buffer side |
| rx_out_data | output | 32 | Oldest receive entry |
| rx_out_ready | input | 1 | Buffer side takes the entry this cycle |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_overrun | output | 1 | Sticky: a byte was dropped |
| tx_wr_valid | input | 1 | Write a byte into the transmit queue |
| tx_wr_data | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit queue full at the current length |
| tx_empty | output | 1 | Transmit queue empty |
| tx_req | input | 1 | Serializer takes a byte this cycle |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_underrun | output | 1 | Sticky: a request found the queue empty |

## Verification
The hardest case to reach is a mode change while a word is only partly packed, because the leftover lanes never show at the ports. To reach it, the stimulus first puts two bytes into word mode. It then switches to character mode and back, and sends a fresh group of four. The stored word must hold only the new bytes. Overrun is reached by holding rx_out_ready low in both modes until the queue fills, then offering one more byte.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
    localparam int BYTE_W     = 8;
    localparam int RX_LANES   = 4;
    localparam int RX_WORD_W  = RX_LANES * BYTE_W;
    localparam int LANE_W     = $clog2(RX_LANES);
    localparam int RX_SLOTS   = 8;
    localparam int TX_DEPTH   = 32;

    typedef enum logic {RX_WORD = 1'b0, RX_CHAR = 1'b1} rx_mode_e;
    typedef enum logic {TX_DEEP = 1'b0, TX_HOLD = 1'b1} tx_mode_e;

    typedef struct packed {
        logic [RX_WORD_W-BYTE_W-1:0] bytes;
        logic [LANE_W-1:0]           lane;
    } pack_st_t;

    function automatic logic [RX_WORD_W-1:0] widen_char(input logic [BYTE_W-1:0] c);
        return {{(RX_WORD_W-BYTE_W){1'b0}}, c};
    endfunction
endpackage

// File: rtl/sdf_ring.sv
module sdf_ring #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [CNT_W-1:0] cap,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] cnt;
    logic do_push, do_pop;

    assign full    = (cnt >= cap);
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push && !flush && !rst) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == PTR_W'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PTR_W'(DEPTH-1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end
endmodule

// File: rtl/sdf_rx_packer.sv
module sdf_rx_packer
    import sdf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  rx_mode_e             mode,
    input  logic                 byte_valid,
    input  logic [BYTE_W-1:0]    byte_in,
    input  logic                 accept,
    output logic                 push,
    output logic [RX_WORD_W-1:0] word
);
    pack_st_t st_q;
    logic     take;
    logic     last_lane;

    assign take      = byte_valid && accept;
    assign last_lane = (st_q.lane == LANE_W'(RX_LANES-1));

    always_comb begin
        push = 1'b0;
        word = widen_char(byte_in);
        if (take) begin
            if (mode == RX_CHAR) begin
                push = 1'b1;
            end else if (last_lane) begin
                push = 1'b1;
                word = {byte_in, st_q.bytes};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            st_q <= '0;
        end else if (take && mode == RX_WORD) begin
            if (last_lane) begin
                st_q.lane <= '0;
            end else begin
                st_q.bytes[int'(st_q.lane)*BYTE_W +: BYTE_W] <= byte_in;
                st_q.lane <= st_q.lane + LANE_W'(1);
            end
        end
    end
endmodule

// File: rtl/sdf_top.sv
module sdf_top
    import sdf_pkg::*;
#(
    parameter int RX_DEPTH = sdf_pkg::RX_SLOTS,
    parameter int TX_LEN   = sdf_pkg::TX_DEPTH
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_narrow,
    input  logic        tx_single,
    input  logic        rx_byte_valid,
    input  logic [7:0]  rx_byte,
    output logic        rx_out_valid,
    output logic [31:0] rx_out_data,
    input  logic        rx_out_ready,
    output logic        rx_full,
    output logic        rx_empty,
    output logic        rx_overrun,
    input  logic        tx_wr_valid,
    input  logic [7:0]  tx_wr_data,
    output logic        tx_full,
    output logic        tx_empty,
    input  logic        tx_req,
    output logic [7:0]  tx_byte,
    output logic        tx_underrun
);
    localparam int RX_CNT_W = $clog2(RX_DEPTH + 1);
    localparam int TX_CNT_W = $clog2(TX_LEN + 1);

    rx_mode_e rx_mode, rx_mode_q;
    tx_mode_e tx_mode, tx_mode_q;
    logic     rx_flush, tx_flush;
    logic     pk_push;
    logic [RX_WORD_W-1:0] pk_word;
    logic [TX_CNT_W-1:0]  tx_cap;

    assign rx_mode  = rx_mode_e'(rx_narrow);
    assign tx_mode  = tx_mode_e'(tx_single);
    assign rx_flush = (rx_mode != rx_mode_q);
    assign tx_flush = (tx_mode != tx_mode_q);
    assign tx_cap   = (tx_mode == TX_HOLD) ? TX_CNT_W'(1) : TX_CNT_W'(TX_LEN);

    always_ff @(posedge clk) begin
        rx_mode_q <= rx_mode;
        tx_mode_q <= tx_mode;
    end

    always_ff @(posedge clk) begin
        if (rst || rx_flush)              rx_overrun <= 1'b0;
        else if (rx_byte_valid && rx_full) rx_overrun <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || tx_flush)         tx_underrun <= 1'b0;
        else if (tx_req && tx_empty) tx_underrun <= 1'b1;
    end

    sdf_rx_packer u_pack (
        .clk        (clk),
        .rst        (rst),
        .flush      (rx_flush),
        .mode       (rx_mode),
        .byte_valid (rx_byte_valid),
        .byte_in    (rx_byte),
        .accept     (!rx_full),
        .push       (pk_push),
        .word       (pk_word)
    );

    sdf_ring #(.WIDTH(RX_WORD_W), .DEPTH(RX_DEPTH)) u_rx_ring (
        .clk   (clk),
        .rst   (rst),
        .flush (rx_flush),
        .cap   (RX_CNT_W'(RX_DEPTH)),
        .push  (pk_push),
        .din   (pk_word),
        .pop   (rx_out_ready),
        .dout  (rx_out_data),
        .full  (rx_full),
        .empty (rx_empty)
    );

    assign rx_out_valid = !rx_empty;

    sdf_ring #(.WIDTH(BYTE_W), .DEPTH(TX_LEN)) u_tx_ring (
        .clk   (clk),
        .rst   (rst),
        .flush (tx_flush),
        .cap   (tx_cap),
        .push  (tx_wr_valid),
        .din   (tx_wr_data),
        .pop   (tx_req),
        .dout  (tx_byte),
        .full  (tx_full),
        .empty (tx_empty)
    );
endmodule

// File: rtl/sdf_checker.sv
module sdf_checker (
    input logic clk,
    input logic rst,
    input logic rx_narrow,
    input logic tx_single,
    input logic rx_byte_valid,
    input logic rx_full,
    input logic rx_empty,
    input logic rx_overrun,
    input logic tx_full,
    input logic tx_empty,
    input logic tx_req,
    input logic tx_underrun
);
    AST_CHAR_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (rx_narrow && $stable(rx_narrow) && rx_byte_valid && rx_empty) |=> !rx_empty) // R3
        else $error("AST_CHAR_RELEASE");

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
        (rx_byte_valid && rx_full && $stable(rx_narrow)) |=> rx_overrun) // R4
        else $error("AST_OVERRUN_SET");

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (rx_overrun && $stable(rx_narrow)) |=> rx_overrun) // R4
        else $error("AST_OVERRUN_STICKY");

    AST_TX_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(tx_full && tx_empty)) // R5
        else $error("AST_TX_FLAGS_EXCL");

    AST_HOLD_FULL: assert property (@(posedge clk) disable iff (rst)
        (tx_single && $stable(tx_single) && !tx_empty) |-> tx_full) // R6
        else $error("AST_HOLD_FULL");

    AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (rst)
        (tx_req && tx_empty && $stable(tx_single)) |=> tx_underrun) // R7
        else $error("AST_UNDERRUN_SET");

    AST_RX_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (rx_narrow != $past(rx_narrow)) |=> (rx_empty && !rx_overrun)) // R8
        else $error("AST_RX_FLUSH");

    AST_TX_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (tx_single != $past(tx_single)) |=> (tx_empty && !tx_underrun)) // R9
        else $error("AST_TX_FLUSH");
endmodule

bind sdf_top sdf_checker u_sdf_checker (
    .clk           (clk),
    .rst           (rst),
    .rx_narrow     (rx_narrow),
    .tx_single     (tx_single),
    .rx_byte_valid (rx_byte_valid),
    .rx_full       (rx_full),
    .rx_empty      (rx_empty),
    .rx_overrun    (rx_overrun),
    .tx_full       (tx_full),
    .tx_empty      (tx_empty),
    .tx_req        (tx_req),
    .tx_underrun   (tx_underrun)
);

// File: tb/sdf_top_bench.sv
module sdf_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_narrow = 1'b0, tx_single = 1'b0;
    logic        rx_byte_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_out_valid;
    logic [31:0] rx_out_data;
    logic        rx_out_ready = 1'b0;
    logic        rx_full, rx_empty, rx_overrun;
    logic        tx_wr_valid = 1'b0;
    logic [7:0]  tx_wr_data = '0;
    logic        tx_full, tx_empty;
    logic        tx_req = 1'b0;
    logic [7:0]  tx_byte;
    logic        tx_underrun;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [31:0] rx_q [$];
    logic [7:0]  tx_q [$];
    logic [7:0]  lanes [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sdf_top u_sdf_top (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor for the receive output
    always @(negedge clk) begin
        if (!rst && rx_out_valid && rx_out_ready) begin
            if (rx_q.size() == 0) check("R2/R3 unexpected entry", rx_out_data, 32'hxxxxxxxx);
            else check("R2/R3 entry", rx_out_data, rx_q.pop_front());
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic rx_send(input logic [7:0] b, input bit drop);
        @(posedge clk); #1;
        rx_byte_valid = 1'b1; rx_byte = b;
        if (!drop) begin
            if (rx_narrow) rx_q.push_back({24'h0, b});
            else begin
                lanes.push_back(b);
                if (lanes.size() == 4) begin
                    rx_q.push_back({lanes[3], lanes[2], lanes[1], lanes[0]});
                    lanes.delete();
                end
            end
        end
        @(posedge clk); #1;
        rx_byte_valid = 1'b0;
    endtask

    task automatic tx_write(input logic [7:0] b, input bit accept);
        @(posedge clk); #1;
        tx_wr_valid = 1'b1; tx_wr_data = b;
        if (accept) tx_q.push_back(b);
        @(posedge clk); #1;
        tx_wr_valid = 1'b0;
    endtask

    task automatic tx_pull(input string req);
        @(posedge clk); #1;
        check(req, 32'(tx_empty), 32'(tx_q.size() == 0));
        if (tx_q.size() != 0) check(req, 32'(tx_byte), 32'(tx_q.pop_front()));
        tx_req = 1'b1;
        @(posedge clk); #1;
        tx_req = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        check("R1 rx_empty", 32'(rx_empty), 1);
        check("R1 tx_empty", 32'(tx_empty), 1);
        check("R1 rx_full", 32'(rx_full), 0);
        check("R1 tx_full", 32'(tx_full), 0);
        check("R1 valid", 32'(rx_out_valid), 0);
        check("R1 flags", {30'h0, rx_overrun, tx_underrun}, 0);

        // R2 word packing
        rx_out_ready = 1'b1;
        for (int i = 0; i < 3; i++) begin
            rx_send(8'h11 * (i + 1), 1'b0);
            check("R2 held until 4 bytes", 32'(rx_empty), 1);
        end
        rx_send(8'h44, 1'b0);
        check("R2 word released", 32'(rx_empty), 0);
        tick(2);
        rx_send(8'hA0, 1'b0); rx_send(8'hB1, 1'b0);
        rx_send(8'hC2, 1'b0); rx_send(8'hD3, 1'b0);
        tick(2);

        // R4 word-mode capacity and overrun
        rx_out_ready = 1'b0;
        for (int i = 0; i < 32; i++) rx_send(8'(i * 7 + 3), 1'b0);
        check("R4 full at 8 words", 32'(rx_full), 1);
        check("R4 no overrun yet", 32'(rx_overrun), 0);
        rx_send(8'hEE, 1'b1);
        check("R4 overrun set", 32'(rx_overrun), 1);
        rx_out_ready = 1'b1;
        tick(12);
        check("R4 drained exactly 8", 32'(rx_q.size()), 0);
        check("R4 overrun sticky", 32'(rx_overrun), 1);

        // partial word, then mode change (R8)
        rx_out_ready = 1'b0;
        rx_send(8'h55, 1'b0); rx_send(8'h66, 1'b0);
        rx_narrow = 1'b1; lanes.delete();
        tick(1);
        check("R8 empty after change", 32'(rx_empty), 1);
        check("R8 overrun cleared", 32'(rx_overrun), 0);

        // R3 character mode
        rx_out_ready = 1'b1;
        for (int i = 0; i < 3; i++) begin
            rx_send(8'h20 + 8'(i), 1'b0);
            check("R3 char released", 32'(rx_empty), 0);
        end
        tick(2);
        rx_out_ready = 1'b0;
        for (int i = 0; i < 8; i++) rx_send(8'h80 + 8'(i), 1'b0);
        check("R4 full at 8 chars", 32'(rx_full), 1);
        rx_send(8'hFF, 1'b1);
        check("R4 char overrun", 32'(rx_overrun), 1);
        rx_out_ready = 1'b1;
        tick(12);
        check("R4 char drained", 32'(rx_q.size()), 0);

        // R8 back to word mode with stored data; partial lanes gone
        rx_out_ready = 1'b0;
        rx_send(8'h01, 1'b0); rx_send(8'h02, 1'b0);
        rx_narrow = 1'b0; rx_q.delete(); lanes.delete();
        tick(1);
        check("R8 flushed entries", 32'(rx_empty), 1);
        check("R8 overrun cleared", 32'(rx_overrun), 0);
        rx_out_ready = 1'b1;
        rx_send(8'h9A, 1'b0); rx_send(8'hBC, 1'b0);
        rx_send(8'hDE, 1'b0); rx_send(8'hF0, 1'b0);
        tick(3);
        check("R8 packer restarted", 32'(rx_q.size()), 0);

        // R5 deep transmit queue
        for (int i = 0; i < 32; i++) tx_write(8'(i * 5 + 1), 1'b1);
        check("R5 full at 32", 32'(tx_full), 1);
        tx_write(8'h77, 1'b0);
        for (int i = 0; i < 32; i++) tx_pull("R5 order");
        check("R5 empty after 32", 32'(tx_empty), 1);
        check("R7 no underrun yet", 32'(tx_underrun), 0);
        tx_pull("R7 pull empty");
        check("R7 underrun set", 32'(tx_underrun), 1);
        tick(2);
        check("R7 underrun sticky", 32'(tx_underrun), 1);

        // R9 / R6 single holding byte
        tx_write(8'h3C, 1'b1);
        tx_single = 1'b1; tx_q.delete();
        tick(1);
        check("R9 tx flushed", 32'(tx_empty), 1);
        check("R9 underrun cleared", 32'(tx_underrun), 0);
        tx_write(8'h5A, 1'b1);
        check("R6 full at 1", 32'(tx_full), 1);
        tx_write(8'hA5, 1'b0);
        tx_pull("R6 holding byte");
        check("R6 empty after pull", 32'(tx_empty), 1);

        tick(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule